// File: doc/BRIEF.md
# Repeat-loop and breakpoint PC sequencer

This block owns the program counter of a word-addressed processor. Each time an issue group retires (`issue_i`), it picks the next PC from the group's own branch, from a hardware repeat loop, from an instruction breakpoint or from an exception vector. The fetch byte address is the PC shifted left by two.

When a loop event occurs, the block also produces the updated repeat count and repeat-enable value. When an exception or a breakpoint is taken, it produces the masked processor status word. Instruction execution, address translation and the status word register itself live outside the block. The block only returns values plus a one-cycle write strobe for each.

All outputs are registered. They change on the clock edge that samples `issue_i` high. When `issue_i` is low, the PC and every held output stay unchanged.

Top module: `pc_sequencer`

## Requirements
- R1: After reset `pc_o` is word 0xFFC0, `fetch_addr_o` is 0x3FF00, and `rpt_upd_o`, `psw_wr_o` and `bus_err_o` are low; `rpt_en_o`, `rpt_cnt_o` and `psw_o` are zero.
- R2: A cycle with `issue_i` low leaves `pc_o`, `rpt_cnt_o`, `rpt_en_o` and `psw_o` unchanged, and all three strobes are low on the following cycle.
- R3: A group with no branch, loop, breakpoint, exception or fault advances the PC by one, modulo 2^PC_W (0xFFFF wraps to 0x0000).
- R4: `fetch_addr_o` always equals `pc_o` with two zero bits appended below it.
- R5: A taken branch (`br_taken_i`) loads `br_target_i`. This includes a branch sitting at the loop-end address, which wins over the loop branch and leaves the repeat count untouched (`rpt_upd_o` low). A branch that targets the loop end lets that word execute before the loop is taken.
- R6: With `rpt_en_i` high, the PC equal to `rpt_end_i`, no branch and `rpt_cnt_i` above 1, the next PC is `rpt_start_i`. In that case `rpt_cnt_o` becomes `rpt_cnt_i`-1, `rpt_en_o` is 1 and `rpt_upd_o` pulses.
- R7: The same loop-end match with `rpt_cnt_i` of 1 or 0 exits the loop: the PC goes to PC+1, `rpt_cnt_o` becomes 0, `rpt_en_o` becomes 0 and `rpt_upd_o` pulses.
- R8: With `dbg_en_i` high and the PC equal to `bkpt_addr_i`, the next PC is DBG_VEC (default 0xFFC8). This overrides a taken branch and a loop branch, and no repeat update is made. `psw_o` becomes `psw_i` with every bit cleared except bit 15 (stack mode), and `psw_wr_o` pulses. With `dbg_en_i` low the match has no effect.
- R9: `addr_err_i` sends the PC to AE_VEC (default 0xFFC4) and `rsv_insn_i` sends it to RIE_VEC (default 0xFFC2). The address error wins when both are raised, and both exceptions win over the breakpoint. `psw_o` keeps only bits 3 (F0), 2 (F1) and 0 (carry) of `psw_i`, and `psw_wr_o` pulses.
- R10: `fetch_fault_i` (the fetch failed translation) keeps the PC unchanged and pulses `bus_err_o`. It overrides every other request, and no status or repeat update is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | An issue group retires this cycle |
| fetch_fault_i | input | 1 | Fetch of the current PC failed translation |
| addr_err_i | input | 1 | Address-error exception request |
| rsv_insn_i | input | 1 | Reserved-instruction exception request |
| br_taken_i | input | 1 | The group changed the PC |
| br_target_i | input | PC_W | Branch target word address |
| rpt_en_i | input | 1 | Repeat mode active |
| rpt_start_i | input | PC_W | Loop start word address |
| rpt_end_i | input | PC_W | Loop end word address |
| rpt_cnt_i | input | CNT_W | Remaining repeat count |
| dbg_en_i | input | 1 | Instruction breakpoint enabled |
| bkpt_addr_i | input | PC_W | Breakpoint word address |
| psw_i | input | PSW_W | Current status word |
| pc_o | output | PC_W | Current program counter |
| fetch_addr_o | output | PC_W+2 | Fetch byte address |
| rpt_en_o | output | 1 | Repeat enable to write back |
| rpt_cnt_o | output | CNT_W | Repeat count to write back |
| rpt_upd_o | output | 1 | Repeat state write strobe |
| psw_o | output | PSW_W | Masked status word to write back |
| psw_wr_o | output | 1 | Status word write strobe |
| bus_err_o | output | 1 | Bus error raised by a failed fetch |

## Verification
The sequencer is driven through plain increments, idle cycles, a three-pass repeat loop that runs to its exit, and branches that either sit at the loop end or target it. Together these separate the loop-back path from the exit path, and both from branch priority. Breakpoint matches are applied while a branch is pending and while a loop branch is pending, and once with debug disabled, which shows both the override and the enable gating. Exceptions are raised with a live breakpoint match, together, and one at a time, which pins down their relative priority and the two different status masks. A fetch fault raised with an exception and a branch to 0xFFFF cover the hold and wrap corners.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    EV_SEQ, EV_BRANCH, EV_LOOP_BACK, EV_LOOP_EXIT,
    EV_BKPT, EV_ADDR_ERR, EV_RSV, EV_FAULT
  } pc_ev_e;
endpackage

// File: rtl/pcseq_loop.sv
module pcseq_loop #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             rpt_en_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  rpt_end_i,
  input  logic [CNT_W-1:0] rpt_cnt_i,
  output logic             hit_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  assign hit_o     = rpt_en_i && (pc_i == rpt_end_i);
  assign last_o    = rpt_cnt_i <= CNT_W'(1);
  assign cnt_nxt_o = last_o ? '0 : rpt_cnt_i - CNT_W'(1);
endmodule

// File: rtl/pcseq_arb.sv
module pcseq_arb import pcseq_pkg::*; (
  input  logic   fault_i,
  input  logic   addr_err_i,
  input  logic   rsv_i,
  input  logic   bkpt_hit_i,
  input  logic   br_i,
  input  logic   loop_hit_i,
  input  logic   loop_last_i,
  output pc_ev_e ev_o
);
  // priority: fault > addr err > reserved > breakpoint > branch > loop
  always_comb begin
    if (fault_i)         ev_o = EV_FAULT;
    else if (addr_err_i) ev_o = EV_ADDR_ERR;
    else if (rsv_i)      ev_o = EV_RSV;
    else if (bkpt_hit_i) ev_o = EV_BKPT;
    else if (br_i)       ev_o = EV_BRANCH;
    else if (loop_hit_i) ev_o = loop_last_i ? EV_LOOP_EXIT : EV_LOOP_BACK;
    else                 ev_o = EV_SEQ;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer import pcseq_pkg::*; #(
  parameter int          PC_W     = 16,
  parameter int          CNT_W    = 16,
  parameter int          PSW_W    = 16,
  parameter logic [31:0] RESET_PC = 32'h0000_FFC0,
  parameter logic [31:0] AE_VEC   = 32'h0000_FFC4,
  parameter logic [31:0] RIE_VEC  = 32'h0000_FFC2,
  parameter logic [31:0] DBG_VEC  = 32'h0000_FFC8,
  parameter int          SM_BIT   = 15,
  parameter int          F0_BIT   = 3,
  parameter int          F1_BIT   = 2,
  parameter int          C_BIT    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              fetch_fault_i,
  input  logic              addr_err_i,
  input  logic              rsv_insn_i,
  input  logic              br_taken_i,
  input  logic [PC_W-1:0]   br_target_i,
  input  logic              rpt_en_i,
  input  logic [PC_W-1:0]   rpt_start_i,
  input  logic [PC_W-1:0]   rpt_end_i,
  input  logic [CNT_W-1:0]  rpt_cnt_i,
  input  logic              dbg_en_i,
  input  logic [PC_W-1:0]   bkpt_addr_i,
  input  logic [PSW_W-1:0]  psw_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W+1:0]   fetch_addr_o,
  output logic              rpt_en_o,
  output logic [CNT_W-1:0]  rpt_cnt_o,
  output logic              rpt_upd_o,
  output logic [PSW_W-1:0]  psw_o,
  output logic              psw_wr_o,
  output logic              bus_err_o
);
  localparam logic [PC_W-1:0]  RST_PC   = RESET_PC[PC_W-1:0];
  localparam logic [PC_W-1:0]  AE_PC    = AE_VEC[PC_W-1:0];
  localparam logic [PC_W-1:0]  RIE_PC   = RIE_VEC[PC_W-1:0];
  localparam logic [PC_W-1:0]  DBG_PC   = DBG_VEC[PC_W-1:0];
  localparam logic [PSW_W-1:0] KEEP_EXC = (PSW_W'(1) << F0_BIT) | (PSW_W'(1) << F1_BIT)
                                        | (PSW_W'(1) << C_BIT);
  localparam logic [PSW_W-1:0] KEEP_DBG = PSW_W'(1) << SM_BIT;

  logic [PC_W-1:0]  pc_q, pc_inc, pc_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [PSW_W-1:0] psw_q;
  logic             ren_q, rupd_q, pwr_q, berr_q;
  logic             bkpt_hit, loop_hit, loop_last;
  pc_ev_e           ev;

  assign pc_inc   = pc_q + PC_W'(1);
  assign bkpt_hit = dbg_en_i && (pc_q == bkpt_addr_i);

  pcseq_loop #(.PC_W(PC_W), .CNT_W(CNT_W)) u_loop (
    .rpt_en_i  (rpt_en_i),
    .pc_i      (pc_q),
    .rpt_end_i (rpt_end_i),
    .rpt_cnt_i (rpt_cnt_i),
    .hit_o     (loop_hit),
    .last_o    (loop_last),
    .cnt_nxt_o (cnt_nxt)
  );

  pcseq_arb u_arb (
    .fault_i     (fetch_fault_i),
    .addr_err_i  (addr_err_i),
    .rsv_i       (rsv_insn_i),
    .bkpt_hit_i  (bkpt_hit),
    .br_i        (br_taken_i),
    .loop_hit_i  (loop_hit),
    .loop_last_i (loop_last),
    .ev_o        (ev)
  );

  always_comb begin
    unique case (ev)
      EV_FAULT:     pc_nxt = pc_q;
      EV_ADDR_ERR:  pc_nxt = AE_PC;
      EV_RSV:       pc_nxt = RIE_PC;
      EV_BKPT:      pc_nxt = DBG_PC;
      EV_BRANCH:    pc_nxt = br_target_i;
      EV_LOOP_BACK: pc_nxt = rpt_start_i;
      default:      pc_nxt = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RST_PC;
      cnt_q  <= '0;
      ren_q  <= 1'b0;
      psw_q  <= '0;
      rupd_q <= 1'b0;
      pwr_q  <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      rupd_q <= 1'b0;
      pwr_q  <= 1'b0;
      berr_q <= 1'b0;
      if (issue_i) begin
        pc_q <= pc_nxt;
        unique case (ev)
          EV_LOOP_BACK, EV_LOOP_EXIT: begin
            cnt_q  <= cnt_nxt;
            ren_q  <= (ev == EV_LOOP_BACK);
            rupd_q <= 1'b1;
          end
          EV_ADDR_ERR, EV_RSV: begin
            psw_q <= psw_i & KEEP_EXC;
            pwr_q <= 1'b1;
          end
          EV_BKPT: begin
            psw_q <= psw_i & KEEP_DBG;
            pwr_q <= 1'b1;
          end
          EV_FAULT: berr_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign pc_o         = pc_q;
  assign fetch_addr_o = {pc_q, 2'b00};
  assign rpt_en_o     = ren_q;
  assign rpt_cnt_o    = cnt_q;
  assign rpt_upd_o    = rupd_q;
  assign psw_o        = psw_q;
  assign psw_wr_o     = pwr_q;
  assign bus_err_o    = berr_q;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int          PC_W    = 16,
  parameter int          CNT_W   = 16,
  parameter int          PSW_W   = 16,
  parameter logic [31:0] AE_VEC  = 32'h0000_FFC4,
  parameter logic [31:0] RIE_VEC = 32'h0000_FFC2,
  parameter logic [31:0] DBG_VEC = 32'h0000_FFC8,
  parameter int          SM_BIT  = 15,
  parameter int          F0_BIT  = 3,
  parameter int          F1_BIT  = 2,
  parameter int          C_BIT   = 0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_i,
  input logic             fetch_fault_i,
  input logic             addr_err_i,
  input logic             rsv_insn_i,
  input logic             br_taken_i,
  input logic             rpt_en_i,
  input logic [PC_W-1:0]  rpt_start_i,
  input logic [PC_W-1:0]  rpt_end_i,
  input logic [CNT_W-1:0] rpt_cnt_i,
  input logic             dbg_en_i,
  input logic [PC_W-1:0]  bkpt_addr_i,
  input logic [PSW_W-1:0] psw_i,
  input logic [PC_W-1:0]  pc_o,
  input logic             rpt_en_o,
  input logic [CNT_W-1:0] rpt_cnt_o,
  input logic             rpt_upd_o,
  input logic [PSW_W-1:0] psw_o,
  input logic             psw_wr_o,
  input logic             bus_err_o
);
  localparam logic [PSW_W-1:0] KEEP_EXC = (PSW_W'(1) << F0_BIT) | (PSW_W'(1) << F1_BIT)
                                        | (PSW_W'(1) << C_BIT);
  localparam logic [PSW_W-1:0] KEEP_DBG = PSW_W'(1) << SM_BIT;

  logic clean, bk;
  assign clean = issue_i && !fetch_fault_i && !addr_err_i && !rsv_insn_i;
  assign bk    = dbg_en_i && (pc_o == bkpt_addr_i);

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(pc_o) && !psw_wr_o && !rpt_upd_o && !bus_err_o);

  assert_fault_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && fetch_fault_i |=> bus_err_o && $stable(pc_o) && !psw_wr_o && !rpt_upd_o);

  assert_addr_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !fetch_fault_i && addr_err_i |=>
      pc_o == AE_VEC[PC_W-1:0] && psw_wr_o && psw_o == ($past(psw_i) & KEEP_EXC));

  assert_rsv_insn_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !fetch_fault_i && !addr_err_i && rsv_insn_i |=>
      pc_o == RIE_VEC[PC_W-1:0] && psw_wr_o);

  assert_bkpt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean && bk |=> pc_o == DBG_VEC[PC_W-1:0] && !rpt_upd_o
      && psw_o == ($past(psw_i) & KEEP_DBG));

  assert_loop_back_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean && !bk && !br_taken_i && rpt_en_i && pc_o == rpt_end_i && rpt_cnt_i > CNT_W'(1) |=>
      pc_o == $past(rpt_start_i) && rpt_en_o && rpt_upd_o
      && rpt_cnt_o == $past(rpt_cnt_i) - CNT_W'(1));

  assert_loop_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean && !bk && !br_taken_i && rpt_en_i && pc_o == rpt_end_i && rpt_cnt_i <= CNT_W'(1) |=>
      pc_o == $past(pc_o) + PC_W'(1) && !rpt_en_o && rpt_upd_o && rpt_cnt_o == '0);
endmodule

bind pc_sequencer pc_sequencer_chk #(
  .PC_W(PC_W), .CNT_W(CNT_W), .PSW_W(PSW_W), .AE_VEC(AE_VEC), .RIE_VEC(RIE_VEC),
  .DBG_VEC(DBG_VEC), .SM_BIT(SM_BIT), .F0_BIT(F0_BIT), .F1_BIT(F1_BIT), .C_BIT(C_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(issue_i), .fetch_fault_i(fetch_fault_i),
  .addr_err_i(addr_err_i), .rsv_insn_i(rsv_insn_i), .br_taken_i(br_taken_i),
  .rpt_en_i(rpt_en_i), .rpt_start_i(rpt_start_i), .rpt_end_i(rpt_end_i),
  .rpt_cnt_i(rpt_cnt_i), .dbg_en_i(dbg_en_i), .bkpt_addr_i(bkpt_addr_i), .psw_i(psw_i),
  .pc_o(pc_o), .rpt_en_o(rpt_en_o), .rpt_cnt_o(rpt_cnt_o), .rpt_upd_o(rpt_upd_o),
  .psw_o(psw_o), .psw_wr_o(psw_wr_o), .bus_err_o(bus_err_o)
);

// File: tb/pc_sequencer_tb.sv
`timescale 1ns/1ps
module pc_sequencer_tb;
  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic        rst_ni, issue_i, fetch_fault_i, addr_err_i, rsv_insn_i, br_taken_i;
  logic [15:0] br_target_i, rpt_start_i, rpt_end_i, rpt_cnt_i, bkpt_addr_i, psw_i;
  logic        rpt_en_i, dbg_en_i;
  logic [15:0] pc_o, rpt_cnt_o, psw_o;
  logic [17:0] fetch_addr_o;
  logic        rpt_en_o, rpt_upd_o, psw_wr_o, bus_err_o;

  pc_sequencer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(issue_i), .fetch_fault_i(fetch_fault_i),
    .addr_err_i(addr_err_i), .rsv_insn_i(rsv_insn_i), .br_taken_i(br_taken_i),
    .br_target_i(br_target_i), .rpt_en_i(rpt_en_i), .rpt_start_i(rpt_start_i),
    .rpt_end_i(rpt_end_i), .rpt_cnt_i(rpt_cnt_i), .dbg_en_i(dbg_en_i),
    .bkpt_addr_i(bkpt_addr_i), .psw_i(psw_i), .pc_o(pc_o), .fetch_addr_o(fetch_addr_o),
    .rpt_en_o(rpt_en_o), .rpt_cnt_o(rpt_cnt_o), .rpt_upd_o(rpt_upd_o), .psw_o(psw_o),
    .psw_wr_o(psw_wr_o), .bus_err_o(bus_err_o)
  );

  typedef struct {
    int          due;
    string       tag;
    logic [15:0] pc, cnt, psw;
    logic        en, upd, pw, be;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0, total = 0, bad = 0;
  logic [15:0] m_pc, m_cnt, m_psw;
  logic        m_en;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string tag, input string name, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  // monitor: compare outputs one cycle after the issuing edge
  always @(negedge clk_i) begin
    if (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "pc", 32'(pc_o), 32'(e.pc));
      chk("R4", "fetch", 32'(fetch_addr_o), 32'({e.pc, 2'b00}));
      chk(e.tag, "rpt_cnt", 32'(rpt_cnt_o), 32'(e.cnt));
      chk(e.tag, "rpt_en", 32'(rpt_en_o), 32'(e.en));
      chk(e.tag, "rpt_upd", 32'(rpt_upd_o), 32'(e.upd));
      chk(e.tag, "psw", 32'(psw_o), 32'(e.psw));
      chk(e.tag, "psw_wr", 32'(psw_wr_o), 32'(e.pw));
      chk(e.tag, "bus_err", 32'(bus_err_o), 32'(e.be));
    end
  end

  // driver: model the group at the current inputs, queue the result, advance
  task automatic step(input string tag);
    exp_t e;
    logic bk, lh;
    e.upd = 0; e.pw = 0; e.be = 0;
    if (issue_i) begin
      bk = dbg_en_i && (m_pc == bkpt_addr_i);
      lh = rpt_en_i && (m_pc == rpt_end_i);
      if (fetch_fault_i) e.be = 1;
      else if (addr_err_i) begin m_pc = 16'hFFC4; m_psw = psw_i & 16'h000D; e.pw = 1; end
      else if (rsv_insn_i) begin m_pc = 16'hFFC2; m_psw = psw_i & 16'h000D; e.pw = 1; end
      else if (bk) begin m_pc = 16'hFFC8; m_psw = psw_i & 16'h8000; e.pw = 1; end
      else if (br_taken_i) m_pc = br_target_i;
      else if (lh) begin
        e.upd = 1;
        if (rpt_cnt_i > 16'd1) begin m_pc = rpt_start_i; m_cnt = rpt_cnt_i - 16'd1; m_en = 1; end
        else begin m_pc = m_pc + 16'd1; m_cnt = 16'd0; m_en = 0; end
      end else m_pc = m_pc + 16'd1;
    end
    e.due = cyc + 1; e.tag = tag;
    e.pc = m_pc; e.cnt = m_cnt; e.psw = m_psw; e.en = m_en;
    sb.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic clr();
    issue_i = 1; fetch_fault_i = 0; addr_err_i = 0; rsv_insn_i = 0; br_taken_i = 0;
    br_target_i = '0;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 0; clr(); issue_i = 0;
    rpt_en_i = 0; rpt_start_i = 0; rpt_end_i = 0; rpt_cnt_i = 0;
    dbg_en_i = 0; bkpt_addr_i = 0; psw_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "pc", 32'(pc_o), 32'h0000FFC0);
    chk("R1", "fetch", 32'(fetch_addr_o), 32'h0003FF00);
    chk("R1", "strobes", {29'd0, rpt_upd_o, psw_wr_o, bus_err_o}, 32'd0);
    chk("R1", "held", {15'd0, rpt_en_o, rpt_cnt_o} | 32'(psw_o), 32'd0);
    m_pc = 16'hFFC0; m_cnt = 0; m_psw = 0; m_en = 0;

    clr(); step("R3");                       // FFC1
    issue_i = 0; br_taken_i = 1; br_target_i = 16'h0555; step("R2");  // ignored
    clr(); br_taken_i = 1; br_target_i = 16'h0100; step("R5");         // 0100

    // R6/R7 three-pass loop 0101..0102
    clr(); rpt_en_i = 1; rpt_start_i = 16'h0101; rpt_end_i = 16'h0102; rpt_cnt_i = 3;
    step("R3"); step("R3");                  // 0101, 0102
    step("R6"); rpt_cnt_i = 2;               // back to 0101
    step("R3"); step("R6"); rpt_cnt_i = 1;
    step("R3"); step("R7"); rpt_en_i = 0;    // exit to 0103

    // R5 branch at loop end wins
    rpt_en_i = 1; rpt_end_i = 16'h0103; rpt_cnt_i = 5;
    br_taken_i = 1; br_target_i = 16'h0200; step("R5");
    // R5 branch targeting loop end, then R6 loop taken from it
    rpt_start_i = 16'h0201; rpt_end_i = 16'h0205;
    br_taken_i = 1; br_target_i = 16'h0205; step("R5");
    clr(); step("R6"); rpt_cnt_i = 4;        // 0201

    // R8 breakpoint over branch, over loop, and gated off
    dbg_en_i = 1; bkpt_addr_i = 16'h0201; psw_i = 16'hFFFF;
    br_taken_i = 1; br_target_i = 16'h0300; step("R8");
    clr(); dbg_en_i = 0; br_taken_i = 1; br_target_i = 16'h0205; step("R5");
    clr(); dbg_en_i = 1; bkpt_addr_i = 16'h0205; psw_i = 16'h7ABC; step("R8");
    dbg_en_i = 0; bkpt_addr_i = 16'hFFC8; step("R8");  // FFC9

    // R9 exceptions
    dbg_en_i = 1; bkpt_addr_i = 16'hFFC9; addr_err_i = 1; psw_i = 16'hFFFF; step("R9");
    rsv_insn_i = 1; psw_i = 16'h1234; step("R9");
    clr(); rsv_insn_i = 1; psw_i = 16'hFFF2; step("R9");
    clr(); dbg_en_i = 0;

    // R10 fetch fault
    fetch_fault_i = 1; addr_err_i = 1; psw_i = 16'h8000; step("R10");
    clr(); rpt_en_i = 0;

    // R3 wrap
    br_taken_i = 1; br_target_i = 16'hFFFF; step("R5");
    clr(); step("R3");
    issue_i = 0; step("R2");

    repeat (3) @(negedge clk_i);
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL drain actual=%0d expected=0", sb.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule